// File: doc/BRIEF.md
# Bus Error Capture Register with First-Error Lock

This block is the per-node error status word of a shared system bus interface. Error detectors elsewhere on the node raise one-cycle strobes, one for each error class. The block gathers these strobes into a 32-bit sticky word. Software inspects the word and clears individual bits with write-one-to-clear writes. A companion configuration word holds several controls: a freeze control for diagnosis, the interrupt disables for correctable data errors, the detection disables for the two timeout classes, and the node identity.

With the freeze control set, the first error of a class other than the four data-syndrome flags locks the word. The strobes that caused the lock are still captured in that cycle. While locked, further strobes are ignored so that the captured picture survives, but software clears still take effect. The lock releases when the word becomes all zero, or when software drops the freeze control. An interrupt line summarises the captured bits, with the correctable data classes masked when their disables are set.

Both words are plain control and status registers and carry no data stream, so no pin has a valid/ready handshake. Every write is accepted in the cycle it is presented.

Top module: `berr_capture`

## Requirements
- R1: After a synchronous active-low reset, the error word reads 0, the configuration word reads the NODE_ID parameter in bits 7:4 and zero elsewhere, and lock_o and irq_o are 0.
- R2: While unlocked, a strobe on an implemented error bit sets that bit one clock later, and the bit stays set until software clears it.
- R3: A clear write sets to zero each error bit written as 1 and leaves each bit written as 0 unchanged, one clock later.
- R4: While unlocked, a clear and a strobe on the same bit in the same cycle leave the bit set.
- R5: Error bits 15:11 are not implemented and always read 0, whatever strobes arrive.
- R6: With configuration bit 31 (freeze) set and the block unlocked, a strobe on any implemented bit outside 23:20 sets lock_o one clock later and is captured. While locked, no strobe sets any bit.
- R7: Strobes that fall only on the syndrome bits 23:20 are captured but never set lock_o.
- R8: While locked, clear writes still take effect, and lock_o falls in the same clock in which the error word becomes zero.
- R9: lock_o falls in the same clock in which a configuration write clears bit 31.
- R10: With configuration bit 2 set, strobes on error bit 3 (bank lock timeout) are ignored. With configuration bit 3 set, strobes on error bit 31 (data timeout) are ignored.
- R11: irq_o is the OR of all error bits, except that bit 17 is excluded when configuration bit 0 is set, and bits 19:18 are excluded when configuration bit 1 is set.
- R12: A configuration write stores bits 31, 30, 28 and 11:0 as written, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | Error strobes, one bit for each error class |
| clr_we_i | input | 1 | Clear write enable for the error word |
| clr_data_i | input | 32 | Write-one-to-clear mask |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_data_i | input | 32 | Configuration write data |
| err_word_o | output | 32 | Captured error word |
| cfg_o | output | 32 | Configuration word |
| lock_o | output | 1 | Error word is frozen |
| irq_o | output | 1 | Error interrupt |

## Verification
The assertions hold on every cycle. They check that the unimplemented bits stay zero, that a locked word without a clear write does not change, and that a lock never exists with an empty word or with the freeze control off. They also check that syndrome-only strobes cannot create a lock and that irq_o equals the plain OR when no disables are set. Only the bench scenarios can show the precedence of a strobe over a clear in the same cycle, the masking of the timeout strobes, the writable configuration fields, and the exact clocks in which a lock is released by clearing or by dropping the freeze control.

// File: rtl/berr_pkg.sv
package berr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BIT_LKTO = 3;
  localparam int unsigned BIT_CWD  = 17;
  localparam int unsigned BIT_CRD0 = 18;
  localparam int unsigned BIT_CRD1 = 19;
  localparam int unsigned SYN_LO   = 20;
  localparam int unsigned SYN_HI   = 23;
  localparam int unsigned RSV_LO   = 11;
  localparam int unsigned RSV_HI   = 15;
  localparam int unsigned BIT_DTO  = 31;

  localparam int unsigned CFG_DIS_CWD  = 0;
  localparam int unsigned CFG_DIS_CRD  = 1;
  localparam int unsigned CFG_DIS_LKTO = 2;
  localparam int unsigned CFG_DIS_DTO  = 3;
  localparam int unsigned CFG_FREEZE   = 31;

  localparam logic [WORD_W-1:0] CFG_WR_MASK = 32'hD000_0FFF;

  function automatic logic [WORD_W-1:0] range_mask(input int unsigned lo, input int unsigned hi);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [WORD_W-1:0] SYN_MASK = range_mask(SYN_LO, SYN_HI);
  localparam logic [WORD_W-1:0] RSV_MASK = range_mask(RSV_LO, RSV_HI);
endpackage

// File: rtl/berr_evt_qual.sv
module berr_evt_qual
  import berr_pkg::*;
(
  input  logic [WORD_W-1:0] evt_i,
  input  logic              locked_i,
  input  logic              dis_lkto_i,
  input  logic              dis_dto_i,
  output logic [WORD_W-1:0] acc_o
);
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    if (RSV_MASK[b]) begin : g_rsv
      assign acc_o[b] = 1'b0;
    end else if (b == BIT_LKTO) begin : g_lkto
      assign acc_o[b] = evt_i[b] & ~locked_i & ~dis_lkto_i;
    end else if (b == BIT_DTO) begin : g_dto
      assign acc_o[b] = evt_i[b] & ~locked_i & ~dis_dto_i;
    end else begin : g_std
      assign acc_o[b] = evt_i[b] & ~locked_i;
    end
  end
endmodule

// File: rtl/berr_cfg_reg.sv
module berr_cfg_reg
  import berr_pkg::*;
#(
  parameter logic [3:0] NODE_ID = 4'h5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] cfg_next_o,
  output logic [WORD_W-1:0] cfg_q_o
);
  localparam logic [WORD_W-1:0] CFG_RST = {{(WORD_W-8){1'b0}}, NODE_ID, 4'h0};

  assign cfg_next_o = we_i ? (wdata_i & CFG_WR_MASK) : cfg_q_o;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q_o <= CFG_RST;
    else        cfg_q_o <= cfg_next_o;
  end
endmodule

// File: rtl/berr_lock_ctl.sv
module berr_lock_ctl
  import berr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              freeze_next_i,
  input  logic              word_next_nz_i,
  output logic              locked_o
);
  logic trig;
  logic locked_d;

  assign trig = |(acc_i & ~SYN_MASK);

  always_comb begin
    if (!freeze_next_i)   locked_d = 1'b0;
    else if (locked_o)    locked_d = word_next_nz_i;
    else                  locked_d = trig;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) locked_o <= 1'b0;
    else        locked_o <= locked_d;
  end
endmodule

// File: rtl/berr_capture.sv
module berr_capture
  import berr_pkg::*;
#(
  parameter logic [3:0] NODE_ID = 4'h5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_i,
  input  logic        clr_we_i,
  input  logic [31:0] clr_data_i,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_data_i,
  output logic [31:0] err_word_o,
  output logic [31:0] cfg_o,
  output logic        lock_o,
  output logic        irq_o
);
  logic [WORD_W-1:0] cfg_next;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] clr_mask;
  logic [WORD_W-1:0] irq_mask;

  berr_cfg_reg #(.NODE_ID(NODE_ID)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_data_i),
    .cfg_next_o (cfg_next),
    .cfg_q_o    (cfg_o)
  );

  berr_evt_qual u_qual (
    .evt_i      (evt_i),
    .locked_i   (lock_o),
    .dis_lkto_i (cfg_o[CFG_DIS_LKTO]),
    .dis_dto_i  (cfg_o[CFG_DIS_DTO]),
    .acc_o      (acc)
  );

  assign clr_mask = clr_we_i ? clr_data_i : '0;
  assign word_d   = (word_q & ~clr_mask) | acc;

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  berr_lock_ctl u_lock (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_i          (acc),
    .freeze_next_i  (cfg_next[CFG_FREEZE]),
    .word_next_nz_i (|word_d),
    .locked_o       (lock_o)
  );

  always_comb begin
    irq_mask = '1;
    irq_mask[BIT_CWD]  = ~cfg_o[CFG_DIS_CWD];
    irq_mask[BIT_CRD0] = ~cfg_o[CFG_DIS_CRD];
    irq_mask[BIT_CRD1] = ~cfg_o[CFG_DIS_CRD];
  end

  assign irq_o      = |(word_q & irq_mask);
  assign err_word_o = word_q;
endmodule

// File: rtl/berr_capture_chk.sv
module berr_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_i,
  input logic        clr_we_i,
  input logic [31:0] err_word_o,
  input logic [31:0] cfg_o,
  input logic        lock_o,
  input logic        irq_o
);
  // R5
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_word_o[15:11] == 5'b0);

  // R6
  frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !clr_we_i) |=> $stable(err_word_o));

  // R7
  syn_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && ((evt_i & 32'hFF0F_FFFF) == 32'h0)) |=> !lock_o);

  // R8
  lock_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (err_word_o != 32'h0));

  // R9
  lock_needs_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> cfg_o[31]);

  // R11
  irq_plain_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_o[0] && !cfg_o[1]) |-> (irq_o == (|err_word_o)));
endmodule

bind berr_capture berr_capture_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .clr_we_i   (clr_we_i),
  .err_word_o (err_word_o),
  .cfg_o      (cfg_o),
  .lock_o     (lock_o),
  .irq_o      (irq_o)
);

// File: tb/tb_berr_capture.sv
module tb_berr_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic        clr_we_i = 1'b0;
  logic [31:0] clr_data_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_data_i = '0;
  logic [31:0] err_word_o;
  logic [31:0] cfg_o;
  logic        lock_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int wd = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_word, m_cfg;
  logic        m_lock;
  bit          m_valid = 0;

  always #2 clk = ~clk;

  berr_capture #(.NODE_ID(4'h5)) dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_we_i(clr_we_i),
    .clr_data_i(clr_data_i), .cfg_we_i(cfg_we_i), .cfg_data_i(cfg_data_i),
    .err_word_o(err_word_o), .cfg_o(cfg_o), .lock_o(lock_o), .irq_o(irq_o)
  );

  // behavioural model, updated from the inputs sampled at each rising edge
  always @(posedge clk) begin
    logic [31:0] acc, nword, ncfg;
    logic nlock;
    if (!rst_n) begin
      m_word = 0; m_cfg = 32'h50; m_lock = 0; m_valid = 1;
    end else if (m_valid) begin
      acc = m_lock ? 32'h0 : (evt_i & ~32'h0000_F800);
      if (m_cfg[2]) acc[3] = 1'b0;
      if (m_cfg[3]) acc[31] = 1'b0;
      nword = m_word;
      if (clr_we_i) nword = nword & ~clr_data_i;
      nword = nword | acc;
      ncfg = cfg_we_i ? (cfg_data_i & 32'hD000_0FFF) : m_cfg;
      if (!ncfg[31])   nlock = 0;
      else if (m_lock) nlock = (nword != 0);
      else             nlock = ((acc & ~32'h00F0_0000) != 0);
      m_word = nword; m_cfg = ncfg; m_lock = nlock;
    end
  end

  function automatic logic model_irq();
    logic [31:0] w;
    w = m_word;
    if (m_cfg[0]) w[17] = 1'b0;
    if (m_cfg[1]) w[19:18] = 2'b00;
    return |w;
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (m_valid && !done) begin
      n_chk++;
      if (err_word_o !== m_word || cfg_o !== m_cfg || lock_o !== m_lock || irq_o !== model_irq()) begin
        n_fail++;
        $display("FAIL MODEL act w=%h c=%h l=%b i=%b exp w=%h c=%h l=%b i=%b",
                 err_word_o, cfg_o, lock_o, irq_o, m_word, m_cfg, m_lock, model_irq());
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] e, input logic cw, input logic [31:0] c,
                     input logic fw, input logic [31:0] f);
    evt_i = e; clr_we_i = cw; clr_data_i = c; cfg_we_i = fw; cfg_data_i = f;
    @(negedge clk);
    evt_i = 0; clr_we_i = 0; clr_data_i = 0; cfg_we_i = 0; cfg_data_i = 0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 5000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL WATCHDOG actual=%0d expected<5000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 word", err_word_o, 32'h0);
    chk("R1 cfg", cfg_o, 32'h50);
    chk("R1 lock/irq", {30'h0, lock_o, irq_o}, 32'h0);
    // R2 capture and stickiness
    cyc(32'h2, 0, 0, 0, 0);
    chk("R2 set", err_word_o, 32'h2);
    cyc(32'h1_0000, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R2 sticky", err_word_o, 32'h1_0002);
    chk("R11 irq", {31'h0, irq_o}, 32'h1);
    // R3 write-one-to-clear
    cyc(0, 1, 32'h2, 0, 0);
    chk("R3 clear", err_word_o, 32'h1_0000);
    // R4 strobe wins over clear
    cyc(32'h1_0000, 1, 32'h1_0000, 0, 0);
    chk("R4 event wins", err_word_o, 32'h1_0000);
    cyc(0, 1, 32'hFFFF_FFFF, 0, 0);
    chk("R3 clear all", err_word_o, 32'h0);
    // R5 unimplemented bits
    cyc(32'h0000_F800, 0, 0, 0, 0);
    chk("R5 reserved", err_word_o, 32'h0);
    // R10 timeout disables
    cyc(0, 0, 0, 1, 32'h5C);
    cyc(32'h8000_0008, 0, 0, 0, 0);
    chk("R10 disabled", err_word_o, 32'h0);
    cyc(0, 0, 0, 1, 32'h50);
    cyc(32'h8000_0008, 0, 0, 0, 0);
    chk("R10 enabled", err_word_o, 32'h8000_0008);
    cyc(0, 1, 32'hFFFF_FFFF, 0, 0);
    // R11 correctable masking
    cyc(0, 0, 0, 1, 32'h53);
    cyc(32'h0006_0000, 0, 0, 0, 0);
    chk("R11 masked", {31'h0, irq_o}, 32'h0);
    cyc(0, 0, 0, 1, 32'h51);
    chk("R11 crd unmasked", {31'h0, irq_o}, 32'h1);
    cyc(0, 1, 32'hFFFF_FFFF, 1, 32'h50);
    // R12 writable fields
    cyc(0, 0, 0, 1, 32'hFFFF_FFFF);
    chk("R12 cfg", cfg_o, 32'hD000_0FFF);
    cyc(0, 0, 0, 1, 32'h8000_0050);
    // R7 syndrome only
    cyc(32'h00F0_0000, 0, 0, 0, 0);
    chk("R7 captured", err_word_o, 32'h00F0_0000);
    chk("R7 no lock", {31'h0, lock_o}, 32'h0);
    cyc(0, 1, 32'hFFFF_FFFF, 0, 0);
    // R6 lock on first error
    cyc(32'h10, 0, 0, 0, 0);
    chk("R6 lock", {31'h0, lock_o}, 32'h1);
    cyc(32'h20, 0, 0, 0, 0);
    chk("R6 frozen", err_word_o, 32'h10);
    // R8 clears while locked, release on empty
    cyc(32'h1, 0, 0, 0, 0);
    cyc(32'h2, 1, 32'h10, 0, 0);
    chk("R8 clear while locked", err_word_o, 32'h0);
    chk("R8 released", {31'h0, lock_o}, 32'h0);
    cyc(32'h11, 0, 0, 0, 0);
    cyc(32'h2, 1, 32'h1, 0, 0);
    chk("R8 partial", err_word_o, 32'h10);
    chk("R8 still locked", {31'h0, lock_o}, 32'h1);
    cyc(0, 1, 32'h10, 0, 0);
    chk("R8 empty release", {31'h0, lock_o}, 32'h0);
    // R9 release by dropping freeze
    cyc(32'h40, 0, 0, 0, 0);
    chk("R9 locked", {31'h0, lock_o}, 32'h1);
    cyc(0, 0, 0, 1, 32'h50);
    chk("R9 released", {31'h0, lock_o}, 32'h0);
    chk("R9 kept", err_word_o, 32'h40);
    cyc(32'h80, 0, 0, 0, 0);
    chk("R9 capture resumes", err_word_o, 32'hC0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule